// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers up to a parameterised number of interrupt lines and turns them into a single request to a processor core. Each line has an enable bit, a pending flag, a trigger mode and a priority byte. Only the upper four bits of the priority byte count, which gives 16 urgency levels where 0 is the most urgent. A line can be level-sensitive or rising-edge-sensitive. An event on a line marks it pending. Among lines that are both pending and enabled, the controller picks the most urgent one and drives `irq_req` and `irq_id` from registers.

The core accepts the offered interrupt by pulsing `irq_ack`. On acknowledge the controller clears that line's pending flag and pushes the line's level and number onto an internal stack of active handlers. A later request is offered only when its level is numerically strictly below the level on top of that stack. A request that is masked or outranked stays pending until it can be delivered. When the handler finishes, the core pulses `irq_eoi`. This pops the stack and restores the previous level. A level-sensitive line that is still asserted at that point becomes pending again.

Configuration uses write strobes that share one bit-mask bus. There are strobes for set-enable, clear-enable, clear-pending and trigger mode, plus an indexed byte write for the priorities.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset `irq_req` is 0 and `irq_id` is 0. No line is enabled, pending or active, and every line is level-sensitive.
- R2: Only bits 7:4 of a priority byte set the level. Two bytes that differ only in bits 3:0 give equal levels.
- R3: Among enabled pending lines, the line with the numerically smallest level is offered.
- R4: When two or more such lines share the smallest level, the lowest-numbered line is offered.
- R5: A set-enable write enables every line whose mask bit is 1 and leaves the lines with 0 bits unchanged. A clear-enable write disables every line whose mask bit is 1.
- R6: A request on a disabled line is held pending and is offered once the line is enabled.
- R7: An accepted acknowledge clears the offered line's pending flag. `irq_req` reads 0 in the cycle after the acknowledge.
- R8: While a handler is active, a pending line is offered only if its level is strictly smaller than the active level. A line of equal or larger level stays pending.
- R9: End-of-interrupt pops the active stack and restores the previous active level. When the stack becomes empty, any pending enabled line can be offered.
- R10: A line in edge mode (mode bit 1) becomes pending once per rising edge. Holding it high does not make it pending again after end-of-interrupt.
- R11: A line in level mode (mode bit 0) that is still asserted after its end-of-interrupt becomes pending again. While its handler is active, it is not made pending again.
- R12: A clear-pending write drops the pending flag of every line whose mask bit is 1.
- R13: `irq_req` is registered. It rises one cycle after the edge that enables a pending line. An `irq_ack` pulse while `irq_req` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_IRQ | Interrupt lines |
| set_en_we | input | 1 | Strobe: enable lines selected by `cfg_mask` |
| clr_en_we | input | 1 | Strobe: disable lines selected by `cfg_mask` |
| clr_pend_we | input | 1 | Strobe: drop pending flags selected by `cfg_mask` |
| mode_we | input | 1 | Strobe: load trigger modes from `cfg_mask` (1 = edge) |
| cfg_mask | input | N_IRQ | Bit mask for the strobes above |
| prio_we | input | 1 | Strobe: write one priority byte |
| prio_idx | input | ID_W | Line number for the priority write |
| prio_byte | input | 8 | Priority byte; only bits 7:4 are kept |
| irq_ack | input | 1 | Core accepts the offered interrupt |
| irq_eoi | input | 1 | Core finished the current handler |
| irq_req | output | 1 | Interrupt offered to the core |
| irq_id | output | ID_W | Number of the offered line |

## Verification
The assertions check, on every cycle, the properties that hold locally. After an acknowledge `irq_req` drops. A request is never offered while the stack is full. The stack depth stays within bounds and grows by one on a push. Enable and clear-pending writes have their effect one cycle later. Only the bench scenarios can show the end-to-end behaviour. This covers the choice between competing lines (nibble-only compare and the tie to the lower number), the blocking of equal levels and the restore of the previous level after end-of-interrupt. It also covers the re-pend difference between level and edge lines, and the exact one-cycle latency of the registered request.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int PRIO_BYTE_W = 8;
  localparam int LVL_W       = 4;

  typedef logic [LVL_W-1:0] lvl_t;

  // Urgency level carried by a priority byte: upper nibble only.
  function automatic lvl_t lvl_of(input logic [PRIO_BYTE_W-1:0] b);
    return b[PRIO_BYTE_W-1 -: LVL_W];
  endfunction
endpackage

// File: rtl/nic_pend_bank.sv
module nic_pend_bank #(
  parameter int N_IRQ = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             set_en_we,
  input  logic             clr_en_we,
  input  logic             clr_pend_we,
  input  logic             mode_we,
  input  logic [N_IRQ-1:0] cfg_mask,
  input  logic [N_IRQ-1:0] ack_clr,
  input  logic [N_IRQ-1:0] active,
  output logic [N_IRQ-1:0] en_q,
  output logic [N_IRQ-1:0] pend_q
);
  logic [N_IRQ-1:0] in_d_q;
  logic [N_IRQ-1:0] edge_mode_q;
  logic [N_IRQ-1:0] rise, lvl_set, set_vec, sw_clr;

  always_comb begin
    rise    = irq_in & ~in_d_q;
    // a level line in service, or being acknowledged now, is not re-pended
    lvl_set = irq_in & ~active & ~ack_clr & ~edge_mode_q;
    set_vec = (rise & edge_mode_q) | lvl_set;
    sw_clr  = clr_pend_we ? cfg_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_d_q      <= '0;
      edge_mode_q <= '0;
      pend_q      <= '0;
      en_q        <= '0;
    end else begin
      in_d_q <= irq_in;
      if (mode_we) edge_mode_q <= cfg_mask;
      pend_q <= ((pend_q & ~ack_clr) | set_vec) & ~sw_clr;
      if (set_en_we)      en_q <= en_q | cfg_mask;
      else if (clr_en_we) en_q <= en_q & ~cfg_mask;
    end
  end

  assert_set_enable_R5: assert property (@(posedge clk) disable iff (rst)
    set_en_we |=> ((en_q & $past(cfg_mask)) == $past(cfg_mask)));

  assert_clear_enable_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_en_we && !set_en_we) |=> ((en_q & $past(cfg_mask)) == '0));

  assert_clear_pending_R12: assert property (@(posedge clk) disable iff (rst)
    clr_pend_we |=> ((pend_q & $past(cfg_mask)) == '0));
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
#(
  parameter int N_IRQ = 32,
  localparam int ID_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic [N_IRQ-1:0] cand,
  input  lvl_t             lvl [N_IRQ],
  output logic             valid,
  output logic [ID_W-1:0]  win_id,
  output lvl_t             win_lvl
);
  // Scan from the top line down; "<=" lets a lower number take a tie.
  always_comb begin
    valid   = 1'b0;
    win_id  = '0;
    win_lvl = '1;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (cand[i] && (!valid || lvl[i] <= win_lvl)) begin
        valid   = 1'b1;
        win_id  = ID_W'(i);
        win_lvl = lvl[i];
      end
    end
  end
endmodule

// File: rtl/nic_level_stack.sv
module nic_level_stack
  import nic_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ID_W  = 5,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic            pop,
  input  lvl_t            push_lvl,
  input  logic [ID_W-1:0] push_id,
  output logic            empty,
  output logic            full,
  output lvl_t            top_lvl,
  output logic [ID_W-1:0] top_id
);
  lvl_t            lvl_mem [DEPTH];
  logic [ID_W-1:0] id_mem  [DEPTH];
  logic [CNT_W-1:0] depth_q;
  logic [IDX_W-1:0] top_idx, wr_idx;

  always_comb begin
    empty   = (depth_q == '0);
    full    = (depth_q == CNT_W'(DEPTH));
    top_idx = IDX_W'(depth_q - 1'b1);
    wr_idx  = IDX_W'(depth_q);
    top_lvl = lvl_mem[top_idx];
    top_id  = id_mem[top_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      depth_q <= '0;
    end else if (push && pop && !empty) begin
      lvl_mem[top_idx] <= push_lvl;
      id_mem[top_idx]  <= push_id;
    end else if (push && !full) begin
      lvl_mem[wr_idx] <= push_lvl;
      id_mem[wr_idx]  <= push_id;
      depth_q         <= depth_q + 1'b1;
    end else if (pop && !empty) begin
      depth_q <= depth_q - 1'b1;
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    depth_q <= CNT_W'(DEPTH));

  assert_push_grows_R9: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !full) |=> (depth_q == $past(depth_q) + 1'b1));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int N_IRQ       = 32,
  parameter int STACK_DEPTH = 16,
  localparam int ID_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_IRQ-1:0]       irq_in,
  input  logic                   set_en_we,
  input  logic                   clr_en_we,
  input  logic                   clr_pend_we,
  input  logic                   mode_we,
  input  logic [N_IRQ-1:0]       cfg_mask,
  input  logic                   prio_we,
  input  logic [ID_W-1:0]        prio_idx,
  input  logic [PRIO_BYTE_W-1:0] prio_byte,
  input  logic                   irq_ack,
  input  logic                   irq_eoi,
  output logic                   irq_req,
  output logic [ID_W-1:0]        irq_id
);
  lvl_t             prio_q [N_IRQ];
  logic [N_IRQ-1:0] en_q, pend_q, active_q;
  logic [N_IRQ-1:0] ack_clr, eoi_clr;
  logic             ack_take, eoi_take, grant_ok;
  logic             win_valid, stk_empty, stk_full;
  logic [ID_W-1:0]  win_id, top_id;
  lvl_t             win_lvl, top_lvl;
  logic             req_q;
  logic [ID_W-1:0]  id_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_IRQ; i++) prio_q[i] <= '0;
    end else if (prio_we) begin
      prio_q[prio_idx] <= lvl_of(prio_byte);
    end
  end

  always_comb begin
    ack_take = irq_ack & req_q;
    eoi_take = irq_eoi & ~stk_empty;
    ack_clr  = '0;
    eoi_clr  = '0;
    if (ack_take) ack_clr[id_q]   = 1'b1;
    if (eoi_take) eoi_clr[top_id] = 1'b1;
    grant_ok = win_valid & ~stk_full & (stk_empty | (win_lvl < top_lvl));
  end

  nic_pend_bank #(.N_IRQ(N_IRQ)) u_pend (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .set_en_we(set_en_we), .clr_en_we(clr_en_we),
    .clr_pend_we(clr_pend_we), .mode_we(mode_we), .cfg_mask(cfg_mask),
    .ack_clr(ack_clr), .active(active_q),
    .en_q(en_q), .pend_q(pend_q)
  );

  nic_arbiter #(.N_IRQ(N_IRQ)) u_arb (
    .cand(pend_q & en_q), .lvl(prio_q),
    .valid(win_valid), .win_id(win_id), .win_lvl(win_lvl)
  );

  nic_level_stack #(.DEPTH(STACK_DEPTH), .ID_W(ID_W)) u_stack (
    .clk(clk), .rst(rst), .push(ack_take), .pop(eoi_take),
    .push_lvl(prio_q[id_q]), .push_id(id_q),
    .empty(stk_empty), .full(stk_full), .top_lvl(top_lvl), .top_id(top_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= '0;
      req_q    <= 1'b0;
      id_q     <= '0;
    end else begin
      active_q <= (active_q & ~eoi_clr) | ack_clr;
      req_q    <= ack_take ? 1'b0 : grant_ok;
      if (grant_ok) id_q <= win_id;
    end
  end

  assign irq_req = req_q;
  assign irq_id  = id_q;

  assert_req_drops_after_ack_R7: assert property (@(posedge clk) disable iff (rst)
    ack_take |=> !irq_req);

  assert_no_req_when_full_R8: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> !stk_full);
endmodule

// File: tb/test_nest_irq_ctrl.sv
`timescale 1ns/1ps
module test_nest_irq_ctrl;
  localparam int N = 32;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_in = '0;
  logic          set_en_we = 0, clr_en_we = 0, clr_pend_we = 0, mode_we = 0;
  logic [N-1:0]  cfg_mask = '0;
  logic          prio_we = 0;
  logic [IW-1:0] prio_idx = '0;
  logic [7:0]    prio_byte = '0;
  logic          irq_ack = 0, irq_eoi = 0;
  logic          irq_req;
  logic [IW-1:0] irq_id;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  nest_irq_ctrl #(.N_IRQ(N), .STACK_DEPTH(16)) i_nest_irq_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .set_en_we(set_en_we), .clr_en_we(clr_en_we), .clr_pend_we(clr_pend_we),
    .mode_we(mode_we), .cfg_mask(cfg_mask),
    .prio_we(prio_we), .prio_idx(prio_idx), .prio_byte(prio_byte),
    .irq_ack(irq_ack), .irq_eoi(irq_eoi),
    .irq_req(irq_req), .irq_id(irq_id)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_req(input string tag, input int exp_req, input int exp_id);
    chk({tag, " req"}, int'(irq_req), exp_req);
    if (exp_req == 1) chk({tag, " id"}, int'(irq_id), exp_id);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; irq_in = '0;
    cyc(2);
    rst = 1'b0;
    cyc(1);
  endtask

  task automatic set_prio(input int idx, input logic [7:0] b);
    prio_we = 1; prio_idx = IW'(idx); prio_byte = b;
    @(negedge clk);
    prio_we = 0;
  endtask

  // kind: 0 set-enable, 1 clear-enable, 2 clear-pending, 3 mode
  task automatic wr(input int kind, input logic [N-1:0] m);
    cfg_mask = m;
    set_en_we   = (kind == 0);
    clr_en_we   = (kind == 1);
    clr_pend_we = (kind == 2);
    mode_we     = (kind == 3);
    @(negedge clk);
    set_en_we = 0; clr_en_we = 0; clr_pend_we = 0; mode_we = 0;
  endtask

  task automatic ack();
    irq_ack = 1; @(negedge clk); irq_ack = 0;
  endtask

  task automatic eoi();
    irq_eoi = 1; @(negedge clk); irq_eoi = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset req", int'(irq_req), 0);
    chk("R1 reset id", int'(irq_id), 0);
    ack();                     // no offer pending: must be ignored (R13)
    set_prio(1, 8'hF0);
    wr(0, 32'h2);
    irq_in[1] = 1;
    cyc(3);
    chk_req("R13 stray ack no effect", 1, 1);
  endtask

  task automatic t_enable();
    do_reset();
    set_prio(3, 8'h50);
    irq_in[3] = 1;
    cyc(3);
    chk_req("R6 masked stays quiet", 0, 0);
    wr(0, 32'h0);
    cyc(2);
    chk_req("R5 zero mask no effect", 0, 0);
    cfg_mask = 32'h8; set_en_we = 1;
    @(negedge clk);
    set_en_we = 0;
    chk_req("R13 not yet after enable edge", 0, 0);
    @(negedge clk);
    chk_req("R13 R6 offered one cycle later", 1, 3);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    chk_req("R7 req drops after ack", 0, 0);
    cyc(4);
    chk_req("R11 no re-pend while active", 0, 0);
    eoi();
    cyc(3);
    chk_req("R11 level re-pends after eoi", 1, 3);
    irq_in[3] = 0;
    wr(2, 32'h8);
    cyc(3);
    chk_req("R12 clear pending drops", 0, 0);
    irq_in[3] = 1;
    wr(1, 32'h8);
    cyc(4);
    chk_req("R5 clear enable masks", 0, 0);
  endtask

  task automatic t_priority();
    do_reset();
    set_prio(0, 8'h3F);
    set_prio(1, 8'h30);
    set_prio(6, 8'h2F);
    set_prio(9, 8'h20);
    wr(0, 32'h243);
    irq_in = 32'h243;
    cyc(3);
    chk_req("R2 R4 low nibble ignored, tie to lower", 1, 6);
    ack(); irq_in[6] = 0;
    cyc(3);
    chk_req("R8 equal level blocked", 0, 0);
    eoi();
    cyc(3);
    chk_req("R3 next most urgent", 1, 9);
    ack(); irq_in[9] = 0;
    eoi();
    cyc(3);
    chk_req("R2 R4 tie among 0x3F and 0x30", 1, 0);
  endtask

  task automatic t_nesting();
    do_reset();
    set_prio(4, 8'h80);
    set_prio(10, 8'h85);
    set_prio(7, 8'h30);
    wr(0, 32'h490);
    irq_in[4] = 1;
    cyc(3);
    chk_req("R3 single line", 1, 4);
    ack();
    irq_in[10] = 1;
    cyc(3);
    chk_req("R8 equal level held pending", 0, 0);
    irq_in[7] = 1;
    cyc(3);
    chk_req("R8 strictly more urgent preempts", 1, 7);
    ack(); irq_in[7] = 0;
    cyc(3);
    chk_req("R8 blocked under nested level", 0, 0);
    eoi();
    cyc(3);
    chk_req("R9 previous level restored", 0, 0);
    irq_in[4] = 0;
    eoi();
    cyc(3);
    chk_req("R9 empty stack releases pending", 1, 10);
  endtask

  task automatic t_edge();
    do_reset();
    set_prio(12, 8'h70);
    wr(3, 32'h1000);
    wr(0, 32'h1000);
    irq_in[12] = 1; @(negedge clk); irq_in[12] = 0;
    cyc(3);
    chk_req("R10 pulse captured", 1, 12);
    ack(); eoi();
    cyc(3);
    chk_req("R10 single pend per pulse", 0, 0);
    irq_in[12] = 1;
    cyc(3);
    chk_req("R10 rising edge while held", 1, 12);
    ack(); eoi();
    cyc(4);
    chk_req("R10 held high no re-pend", 0, 0);
    irq_in[12] = 0;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_enable();
    t_priority();
    t_nesting();
    t_edge();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule